// File: doc/BRIEF.md
# Hart Selection and Status Aggregator

This block is the control and status core of a debug module that steers a group of harts. It holds a hart index, a selection-mode bit and a hart array mask. From these it forms the set of selected harts. Every control write acts on that set. The write can set or clear halt requests, drive hart resets, arm or disarm halt-on-reset, send one-shot resume pulses, and acknowledge reset events. The set used is the one formed from the index and mode carried by that same write.

In the other direction, the block folds per-hart status inputs into any/all flag pairs over the selected set. It also forms a 32-bit halt summary word for the group of 32 harts that contains the indexed hart. The mask can be larger than 32 bits, so it is reached through a window: one register selects a 32-bit slice and a second register reads or writes that slice. The hart count is a parameter of at most 64. An index at or above that count names a hart that does not exist.

A debugger drives the block through a small register port: a request strobe, a write flag, a 3-bit address and 32-bit data. Read data is registered. A module-active bit gates all other state.

Top module: `hart_sel_agg`

## Requirements
- R1: A read request (req_i=1, we_i=0) returns data on rdata_o with rvalid_o=1 in the next cycle only. Addresses: 0 control, 1 status, 2 window select, 3 window data, 4 halt summary.
- R2: Control word bit 0 is the module-active bit. While active is 0, all control state, the mask and the window select are held at 0, and every per-hart output is 0. A control write made while inactive only loads the active bit. Writes to addresses 2 and 3 are ignored. The control register reads back active in bit 0, mode in bit 5 and the index in bits 27:8.
- R3: Control write bits are: 1 halt request, 5 mode, 27:8 index. With mode 0, only the indexed hart is selected. With mode 1, the selection is the indexed hart plus every hart whose mask bit is 1. The halt request outputs of the selected harts take bit 1; other harts keep their value. The selection used is the one formed from the index and mode in that same write.
- R4: Control bit 2 (resume) sends a one-cycle resume_req_o pulse to the selected harts that are halted. It also clears their resume-ack flags. The resume is ignored if bit 1 is also 1 in that write. A resume_ack_i bit sets the hart's flag.
- R5: Control bit 3 writes hart_reset_o for the selected harts.
- R6: Control bit 6 sets hor_req_o for the selected harts unless bit 7 is also 1. Bit 7 alone clears it. Otherwise the value persists across control writes.
- R7: A havereset_i bit sets that hart's reset-seen flag. Control bit 4 clears the flag for the selected harts. An incoming havereset_i wins over a clear in the same cycle.
- R8: Status bits 2k and 2k+1 are the any and all flags over the selected set for these conditions, in this order for k=0..5: halted, running, unavailable, nonexistent, resume-acked, reset-seen. A hart whose unavailable or nonexistent input is 1 is not counted as halted.
- R9: An index at or above N_HARTS counts as a selected hart that is nonexistent and meets no other condition.
- R10: Address 2 holds the window select w. At address 3, bit b maps to mask bit w*32+b. Bits for harts at or above N_HARTS read 0 and cannot be written.
- R11: Halt summary bit i reports whether hart {index[19:5], i[4:0]} is halted, using the R8 meaning of halted. It is 0 for harts that do not exist.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid |
| halted_i | input | N_HARTS | Per-hart halted |
| running_i | input | N_HARTS | Per-hart running |
| unavail_i | input | N_HARTS | Per-hart unavailable |
| nonexist_i | input | N_HARTS | Per-hart nonexistent |
| havereset_i | input | N_HARTS | Per-hart reset event |
| resume_ack_i | input | N_HARTS | Per-hart resume acknowledge |
| halt_req_o | output | N_HARTS | Per-hart halt request |
| resume_req_o | output | N_HARTS | Per-hart one-cycle resume pulse |
| hart_reset_o | output | N_HARTS | Per-hart reset |
| hor_req_o | output | N_HARTS | Per-hart halt-on-reset request |

## Verification
The assertions check, on every cycle:
- read latency;
- that the per-hart outputs clear while the module is inactive;
- that a single-hart write changes at most one halt request;
- that resume pulses come only from a qualifying write and reach only halted harts;
- that halt-on-reset state never changes without a control write.

The directed scenarios are needed for the rest:
- the selection taking the index from the same write;
- mask windowing across slices;
- the any/all flag values for mixed status patterns;
- the phantom nonexistent hart;
- group addressing of the halt summary;
- priority between havereset events and acknowledge writes.

// File: rtl/hsa_pkg.sv
package hsa_pkg;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_WSEL = 3'd2;
  localparam logic [2:0] A_WIN  = 3'd3;
  localparam logic [2:0] A_HSUM = 3'd4;

  localparam int B_ACT  = 0;
  localparam int B_HALT = 1;
  localparam int B_RES  = 2;
  localparam int B_HRST = 3;
  localparam int B_ACK  = 4;
  localparam int B_MODE = 5;
  localparam int B_SET  = 6;
  localparam int B_CLR  = 7;
  localparam int IDX_LSB = 8;

  localparam int N_COND = 6;
  localparam int C_NX   = 3;
endpackage

// File: rtl/hsa_select.sv
module hsa_select #(
  parameter int N_HARTS = 40,
  parameter int IDX_W   = 20
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               mode_i,
  input  logic [N_HARTS-1:0] mask_i,
  output logic [N_HARTS-1:0] sel_o
);
  for (genvar i = 0; i < N_HARTS; i++) begin : g_sel
    assign sel_o[i] = (idx_i == IDX_W'(i)) | (mode_i & mask_i[i]);
  end
endmodule

// File: rtl/hsa_anyall.sv
module hsa_anyall #(
  parameter int N_HARTS = 40,
  parameter bit PH_VAL  = 1'b0
) (
  input  logic [N_HARTS-1:0] sel_i,
  input  logic               ph_i,
  input  logic [N_HARTS-1:0] cond_i,
  output logic               any_o,
  output logic               all_o
);
  assign any_o = (|(sel_i & cond_i)) | (ph_i & PH_VAL);
  assign all_o = (&(~sel_i | cond_i)) & (~ph_i | PH_VAL);
endmodule

// File: rtl/hsa_window.sv
module hsa_window #(
  parameter int N_HARTS = 40,
  parameter int DW      = 32,
  localparam int NWIN   = (N_HARTS + DW - 1) / DW,
  localparam int WS_W   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic               clk,
  input  logic               clr_i,
  input  logic               sel_we_i,
  input  logic               win_we_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [N_HARTS-1:0] mask_o,
  output logic [WS_W-1:0]    wsel_o,
  output logic [DW-1:0]      win_o
);
  logic [N_HARTS-1:0] mask_q;
  logic [WS_W-1:0]    wsel_q;

  always_ff @(posedge clk) begin
    if (clr_i) begin
      mask_q <= '0;
      wsel_q <= '0;
    end else begin
      if (sel_we_i) wsel_q <= wdata_i[WS_W-1:0];
      if (win_we_i) begin
        for (int j = 0; j < N_HARTS; j++)
          if (wsel_q == WS_W'(j / DW)) mask_q[j] <= wdata_i[j % DW];
      end
    end
  end

  always_comb begin
    win_o = '0;
    for (int j = 0; j < N_HARTS; j++)
      if (wsel_q == WS_W'(j / DW)) win_o[j % DW] = mask_q[j];
  end

  assign mask_o = mask_q;
  assign wsel_o = wsel_q;
endmodule

// File: rtl/hart_sel_agg.sv
module hart_sel_agg
  import hsa_pkg::*;
#(
  parameter int N_HARTS = 40,
  parameter int IDX_W   = 20,
  parameter int DW      = 32,
  localparam int NWIN   = (N_HARTS + DW - 1) / DW,
  localparam int WS_W   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [2:0]         addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               rvalid_o,
  input  logic [N_HARTS-1:0] halted_i,
  input  logic [N_HARTS-1:0] running_i,
  input  logic [N_HARTS-1:0] unavail_i,
  input  logic [N_HARTS-1:0] nonexist_i,
  input  logic [N_HARTS-1:0] havereset_i,
  input  logic [N_HARTS-1:0] resume_ack_i,
  output logic [N_HARTS-1:0] halt_req_o,
  output logic [N_HARTS-1:0] resume_req_o,
  output logic [N_HARTS-1:0] hart_reset_o,
  output logic [N_HARTS-1:0] hor_req_o
);
  logic               active_q, mode_q;
  logic [IDX_W-1:0]   idx_q;
  logic [N_HARTS-1:0] halt_q, hrst_q, hor_q, res_q, rack_q, seen_q;
  logic [N_HARTS-1:0] mask, wr_sel, cur_sel, eff_halt;
  logic [WS_W-1:0]    wsel;
  logic [DW-1:0]      win_rd, hsum;
  logic [2*N_COND-1:0] stat;
  logic [N_COND-1:0][N_HARTS-1:0] conds;
  logic               cur_ph;

  wire ctrl_wr = req_i & we_i & (addr_i == A_CTRL);
  wire apply   = ctrl_wr & active_q & wdata_i[B_ACT];
  wire go_res  = apply & wdata_i[B_RES] & ~wdata_i[B_HALT];
  wire clr_all = rst | ~active_q;

  hsa_window #(.N_HARTS(N_HARTS), .DW(DW)) u_win (
    .clk(clk), .clr_i(clr_all),
    .sel_we_i(req_i & we_i & (addr_i == A_WSEL) & active_q),
    .win_we_i(req_i & we_i & (addr_i == A_WIN) & active_q),
    .wdata_i(wdata_i), .mask_o(mask), .wsel_o(wsel), .win_o(win_rd)
  );

  hsa_select #(.N_HARTS(N_HARTS), .IDX_W(IDX_W)) u_sel_wr (
    .idx_i(wdata_i[IDX_LSB +: IDX_W]), .mode_i(wdata_i[B_MODE]),
    .mask_i(mask), .sel_o(wr_sel)
  );

  hsa_select #(.N_HARTS(N_HARTS), .IDX_W(IDX_W)) u_sel_cur (
    .idx_i(idx_q), .mode_i(mode_q), .mask_i(mask), .sel_o(cur_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else if (ctrl_wr) active_q <= wdata_i[B_ACT];
  end

  always_ff @(posedge clk) begin
    if (clr_all) begin
      mode_q <= 1'b0;
      idx_q  <= '0;
      halt_q <= '0;
      hrst_q <= '0;
      hor_q  <= '0;
      res_q  <= '0;
      rack_q <= '0;
      seen_q <= '0;
    end else begin
      if (apply) begin
        mode_q <= wdata_i[B_MODE];
        idx_q  <= wdata_i[IDX_LSB +: IDX_W];
      end
      for (int i = 0; i < N_HARTS; i++) begin
        res_q[i] <= go_res & wr_sel[i] & halted_i[i];
        if (apply && wr_sel[i]) begin
          halt_q[i] <= wdata_i[B_HALT];
          hrst_q[i] <= wdata_i[B_HRST];
          if (wdata_i[B_CLR]) hor_q[i] <= 1'b0;
          else if (wdata_i[B_SET]) hor_q[i] <= 1'b1;
        end
        if (go_res && wr_sel[i]) rack_q[i] <= 1'b0;
        else if (resume_ack_i[i]) rack_q[i] <= 1'b1;
        if (havereset_i[i]) seen_q[i] <= 1'b1;
        else if (apply && wdata_i[B_ACK] && wr_sel[i]) seen_q[i] <= 1'b0;
      end
    end
  end

  assign eff_halt = halted_i & ~unavail_i & ~nonexist_i;
  assign cur_ph   = (idx_q >= IDX_W'(N_HARTS));
  assign conds    = {seen_q, rack_q, nonexist_i, unavail_i, running_i, eff_halt};

  for (genvar k = 0; k < N_COND; k++) begin : g_red
    hsa_anyall #(.N_HARTS(N_HARTS), .PH_VAL(k == C_NX)) u_red (
      .sel_i(cur_sel), .ph_i(cur_ph), .cond_i(conds[k]),
      .any_o(stat[2*k]), .all_o(stat[2*k+1])
    );
  end

  always_comb begin
    hsum = '0;
    for (int j = 0; j < N_HARTS; j++)
      if (idx_q[IDX_W-1:5] == (IDX_W-5)'(j / 32)) hsum[j % 32] = eff_halt[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_i & ~we_i;
      if (req_i && !we_i) begin
        rdata_o <= '0;
        case (addr_i)
          A_CTRL: begin
            rdata_o[B_ACT]  <= active_q;
            rdata_o[B_MODE] <= mode_q;
            rdata_o[IDX_LSB +: IDX_W] <= idx_q;
          end
          A_STAT: rdata_o[2*N_COND-1:0] <= stat;
          A_WSEL: rdata_o[WS_W-1:0] <= wsel;
          A_WIN:  rdata_o <= win_rd;
          A_HSUM: rdata_o <= hsum;
          default: rdata_o <= '0;
        endcase
      end
    end
  end

  assign halt_req_o   = halt_q;
  assign resume_req_o = res_q;
  assign hart_reset_o = hrst_q;
  assign hor_req_o    = hor_q;
endmodule

// File: rtl/hsa_checker.sv
module hsa_checker
  import hsa_pkg::*;
#(
  parameter int N_HARTS = 40
) (
  input logic               clk,
  input logic               rst,
  input logic               req_i,
  input logic               we_i,
  input logic [2:0]         addr_i,
  input logic               w_act,
  input logic               w_halt,
  input logic               w_res,
  input logic               w_mode,
  input logic               rvalid_o,
  input logic               active_q,
  input logic [N_HARTS-1:0] halted_i,
  input logic [N_HARTS-1:0] halt_req_o,
  input logic [N_HARTS-1:0] resume_req_o,
  input logic [N_HARTS-1:0] hart_reset_o,
  input logic [N_HARTS-1:0] hor_req_o
);
  wire c_wr = req_i & we_i & (addr_i == A_CTRL);

  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    (req_i && !we_i) |=> rvalid_o); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !(req_i && !we_i) |=> !rvalid_o); // R1
  AST_INACTIVE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !active_q |=> (halt_req_o == '0 && hart_reset_o == '0 &&
                   hor_req_o == '0 && resume_req_o == '0)); // R2
  AST_SINGLE_SEL: assert property (@(posedge clk) disable iff (rst)
    (c_wr && w_act && !w_mode && active_q) |=>
      ($countones(halt_req_o ^ $past(halt_req_o)) <= 1)); // R3
  AST_RESUME_SRC: assert property (@(posedge clk) disable iff (rst)
    (resume_req_o != '0) |-> $past(c_wr && w_res && !w_halt)); // R4
  AST_RESUME_HALTED: assert property (@(posedge clk) disable iff (rst)
    (resume_req_o & ~$past(halted_i)) == '0); // R4
  AST_HOR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(c_wr) && $past(active_q)) |-> $stable(hor_req_o)); // R6
endmodule

bind hart_sel_agg hsa_checker #(.N_HARTS(N_HARTS)) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .w_act(wdata_i[hsa_pkg::B_ACT]), .w_halt(wdata_i[hsa_pkg::B_HALT]),
  .w_res(wdata_i[hsa_pkg::B_RES]), .w_mode(wdata_i[hsa_pkg::B_MODE]),
  .rvalid_o(rvalid_o), .active_q(active_q), .halted_i(halted_i),
  .halt_req_o(halt_req_o), .resume_req_o(resume_req_o),
  .hart_reset_o(hart_reset_o), .hor_req_o(hor_req_o)
);

// File: tb/hart_sel_agg_tb.sv
`timescale 1ns/1ps
module hart_sel_agg_tb;
  localparam int N = 40;
  logic clk = 0, rst = 1;
  logic req = 0, we = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic rvalid;
  logic [N-1:0] halted = 0, running = 0, unavail = 0, nonexist = 0, haverst = 0, rack = 0;
  logic [N-1:0] haltq, resq, hrstq, horq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  hart_sel_agg #(.N_HARTS(N)) u_dut (
    .clk(clk), .rst(rst), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .halted_i(halted), .running_i(running),
    .unavail_i(unavail), .nonexist_i(nonexist), .havereset_i(haverst),
    .resume_ack_i(rack), .halt_req_o(haltq), .resume_req_o(resq),
    .hart_reset_o(hrstq), .hor_req_o(horq)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
    chk("R1 rvalid", 64'(rvalid), 64'd1);
  endtask

  function automatic logic [31:0] cw(bit h, bit r, bit hr, bit ak, bit m, bit s, bit c, int idx);
    logic [31:0] v;
    v = '0; v[0] = 1; v[1] = h; v[2] = r; v[3] = hr; v[4] = ak;
    v[5] = m; v[6] = s; v[7] = c; v[27:8] = 20'(idx);
    return v;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R2 reset halt", 64'(haltq), 0);
    rd(3'd0, d); chk("R2 reset ctrl", 64'(d), 0);
    wr(3'd0, cw(1,0,0,0,0,0,0,3));
    rd(3'd0, d); chk("R2 first write only active", 64'(d), 1);
    chk("R2 first write no halt", 64'(haltq), 0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    wr(3'd0, cw(1,0,0,0,0,0,0,3)); chk("R3 halt idx3", 64'(haltq), 64'h8);
    wr(3'd0, cw(1,0,0,0,0,0,0,5)); chk("R3 halt idx5", 64'(haltq), 64'h28);
    wr(3'd0, cw(0,0,0,0,0,0,0,3)); chk("R3 clear idx3", 64'(haltq), 64'h20);
    rd(3'd0, d); chk("R3 ctrl readback", 64'(d), 64'h0000_0301);
    wr(3'd0, cw(0,0,0,0,0,0,0,5)); chk("R3 clear idx5", 64'(haltq), 0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(3'd2, 32'd1); wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d); chk("R10 upper slice", 64'(d), 64'hFF);
    wr(3'd2, 32'd0); wr(3'd3, 32'h0000_0011);
    rd(3'd3, d); chk("R10 lower slice", 64'(d), 64'h11);
    wr(3'd0, cw(1,0,0,0,1,0,0,2));
    chk("R3 mask select", 64'(haltq), 64'hFF_0000_0015);
    wr(3'd2, 32'd1); rd(3'd3, d); chk("R10 reread upper", 64'(d), 64'hFF);
  endtask

  task automatic t_status();
    logic [31:0] d;
    halted = '1; rd(3'd1, d); chk("R8 all halted", 64'(d), 64'h003);
    unavail[33] = 1; rd(3'd1, d); chk("R8 unavail not halted", 64'(d), 64'h011);
    unavail = 0; halted = 0; running = '1;
    rd(3'd1, d); chk("R8 all running", 64'(d), 64'h00C);
    running = 0;
  endtask

  task automatic t_sum();
    logic [31:0] d;
    halted = 40'hA5_0000_00F0;
    wr(3'd0, cw(0,0,0,0,0,0,0,35)); rd(3'd4, d); chk("R11 group1", 64'(d), 64'hA5);
    wr(3'd0, cw(0,0,0,0,0,0,0,3));  rd(3'd4, d); chk("R11 group0", 64'(d), 64'hF0);
    rd(3'd1, d); chk("R8 single not halted", 64'(d), 0);
    wr(3'd0, cw(0,0,0,0,0,0,0,4));  rd(3'd1, d); chk("R8 single halted", 64'(d), 64'h3);
  endtask

  task automatic t_nonexist();
    logic [31:0] d;
    wr(3'd0, cw(0,0,0,0,0,0,0,50)); rd(3'd1, d); chk("R9 phantom", 64'(d), 64'hC0);
    rd(3'd4, d); chk("R11 idx50 group", 64'(d), 64'hA5);
    wr(3'd0, cw(0,0,0,0,0,0,0,100)); rd(3'd4, d); chk("R11 empty group", 64'(d), 0);
    wr(3'd0, cw(0,0,0,0,1,0,0,50)); rd(3'd1, d); chk("R9 phantom plus mask", 64'(d), 64'h41);
  endtask

  task automatic t_resume();
    logic [31:0] d;
    wr(3'd0, cw(0,0,0,0,0,0,0,7));
    halted = 40'h80;
    @(negedge clk); rack[7] = 1; @(negedge clk); rack[7] = 0;
    rd(3'd1, d); chk("R4 ack flag set", 64'(d), 64'h303);
    wr(3'd0, cw(0,1,0,0,0,0,0,7)); chk("R4 resume pulse", 64'(resq), 64'h80);
    @(negedge clk); chk("R4 pulse one cycle", 64'(resq), 0);
    rd(3'd1, d); chk("R4 ack cleared", 64'(d), 64'h003);
    wr(3'd0, cw(1,1,0,0,0,0,0,7)); chk("R4 ignored with halt", 64'(resq), 0);
    chk("R3 halt bit7", 64'(haltq[7]), 1);
    halted = 0;
    wr(3'd0, cw(0,1,0,0,0,0,0,7)); chk("R4 running not resumed", 64'(resq), 0);
  endtask

  task automatic t_hor();
    wr(3'd0, cw(0,0,0,0,0,1,0,9));  chk("R6 set", 64'(horq), 64'h200);
    wr(3'd0, cw(0,0,0,0,0,1,1,10)); chk("R6 set and clr", 64'(horq), 64'h200);
    wr(3'd0, cw(0,0,0,0,0,0,0,9));  chk("R6 persists", 64'(horq), 64'h200);
    wr(3'd0, cw(0,0,0,0,0,0,1,9));  chk("R6 clear", 64'(horq), 0);
  endtask

  task automatic t_hreset();
    logic [31:0] d;
    wr(3'd0, cw(0,0,1,0,0,0,0,12)); chk("R5 reset on", 64'(hrstq), 64'h1000);
    wr(3'd0, cw(0,0,0,0,0,0,0,12)); chk("R5 reset off", 64'(hrstq), 0);
    @(negedge clk); haverst[12] = 1; @(negedge clk); haverst[12] = 0;
    rd(3'd1, d); chk("R7 seen", 64'(d), 64'hC00);
    @(negedge clk); haverst[12] = 1;
    wr(3'd0, cw(0,0,0,1,0,0,0,12)); haverst[12] = 0;
    rd(3'd1, d); chk("R7 event wins over ack", 64'(d), 64'hC00);
    wr(3'd0, cw(0,0,0,1,0,0,0,12));
    rd(3'd1, d); chk("R7 ack clears", 64'(d), 0);
  endtask

  task automatic t_deact();
    logic [31:0] d;
    wr(3'd0, cw(1,0,1,0,0,1,0,14));
    wr(3'd0, 32'h0);
    @(negedge clk);
    chk("R2 inactive halt", 64'(haltq), 0);
    chk("R2 inactive reset", 64'(hrstq | horq), 0);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd0, 32'h1);
    rd(3'd3, d); chk("R2 window ignored", 64'(d), 0);
    rd(3'd0, d); chk("R2 ctrl cleared", 64'(d), 1);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_single();
    t_window();
    t_status();
    t_sum();
    t_nonexist();
    t_resume();
    t_hor();
    t_hreset();
    t_deact();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule